// File: doc/BRIEF.md
# EDID Fetch and Validate Sequencer

This block sits on the source side of a display link. It reads the sink's whole capability table (EDID) through a byte-level I2C master and stores it in a local buffer. The bit engine runs the wire, and this block only issues byte commands and consumes their results. When started, it waits for the hot-plug line to be reported stable. It then reads block 0 and checks the fixed eight-byte header and the 128-byte checksum while the bytes stream in. It takes the declared extension count from byte 126 of block 0 and fetches the remaining blocks, up to a configured capacity.

Every block, block 0 included, is addressed by first writing its segment number to the segment-pointer device and then writing its in-segment offset to the table device. The block never relies on the sink resetting the segment pointer. A NACK on any written byte ends the fetch with a STOP and an error code that names the step that failed. Results stay on the outputs until the next start: the buffer contents, the number of blocks fetched, per-block error flags and a header flag.

Top module: `edid_fetch_seq`

## Requirements
- R1: After `fetchStart`, `busy` goes high and no I2C command is issued while `hpdStable` is low. The first command follows once `hpdStable` is high.
- R2: Commands use op codes START=0, WRITE=1, READ=2 and STOP=3. Block B is fetched with this sequence: START, WRITE 0x60, WRITE floor(B/2), START, WRITE 0xA0, WRITE offset (0x00 for even B, 0x80 for odd B), START, WRITE 0xA1, 128 READs, STOP. Block 0 also gets an explicit segment write of 0x00.
- R3: `i2cAckOut` is high when reading bytes 0 to 126 of a block and low when reading byte 127.
- R4: Byte i of block B is written to buffer address B*128+i with the value read.
- R5: `blockBad[B]` is set when the 128 bytes of fetched block B do not sum to zero modulo 256. It is clear otherwise, and bits at or above `blockCount` stay clear.
- R6: `hdrBad` is set, and block 0 counts as bad, when bytes 0 to 7 of block 0 differ from 00 FF FF FF FF FF FF 00.
- R7: The number of blocks fetched is min(byte 126 of block 0 + 1, MAX_BLOCKS). `blockCount` reports how many blocks were fully fetched.
- R8: If block 0 is bad (header or checksum), no further block is fetched and `blockCount` is 1.
- R9: A NACK on any written byte makes the block issue STOP and finish. `errCode` is then set as follows: 1 for the segment device address, 2 for the segment value, 3 for the table write address, 4 for the offset, and 5 for the table read address. `blockCount` is the number of blocks completed before the NACK. Without a NACK, `errCode` is 0.
- R10: `done` rises when the fetch ends and stays high, with `blockCount` and `errCode` unchanged, until the next `fetchStart`. A `fetchStart` while `busy` is high has no effect.
- R11: Each command is a one-cycle `i2cCmdValid` pulse. No new command is issued until `i2cDone` has answered the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchStart | input | 1 | One-cycle request to start a fetch |
| hpdStable | input | 1 | Hot-plug line reported stable |
| i2cCmdValid | output | 1 | Command pulse to the byte engine |
| i2cCmdOp | output | 2 | Command op: 0 START, 1 WRITE, 2 READ, 3 STOP |
| i2cCmdData | output | 8 | Byte to write |
| i2cAckOut | output | 1 | For READ: 1 to ACK the byte, 0 to NACK it |
| i2cDone | input | 1 | Engine finished the current command (one cycle) |
| i2cRdData | input | 8 | Byte read, valid with `i2cDone` |
| i2cNack | input | 1 | Slave NACKed the written byte, valid with `i2cDone` |
| bufWrEn | output | 1 | Buffer write strobe |
| bufWrAddr | output | $clog2(MAX_BLOCKS*128) | Buffer byte address |
| bufWrData | output | 8 | Buffer write data |
| busy | output | 1 | Fetch in progress |
| done | output | 1 | Fetch finished, results valid |
| errCode | output | 3 | Step that was NACKed, 0 if none |
| hdrBad | output | 1 | Block 0 header mismatch |
| blockBad | output | MAX_BLOCKS | Per-block checksum or header failure |
| blockCount | output | $clog2(MAX_BLOCKS+1) | Blocks fully fetched |

## Verification
The assertions check these properties on every cycle: commands are single-cycle pulses, nothing is issued while waiting for hot-plug, a NACK on a written byte is followed by STOP, the results hold still while `done` is high, the block count never exceeds capacity, and the byte index advances once per read. Only the bench scenarios can show the rest. This includes the exact segment and offset bytes written for each block. It also includes the buffer contents compared against the sink image, the clamping of large extension counts, and the halt after a bad block 0. The mapping from NACK position to error code and completed-block count is also checked by the scenarios. The sink model keeps a nonzero segment pointer from the previous fetch, so a missing segment write for block 0 shows up as wrong data.

// File: rtl/edid_fetch_pkg.sv
package edid_fetch_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } i2cOp_e;

  typedef enum logic [2:0] {
    ERR_NONE     = 3'd0,
    ERR_SEG_ADDR = 3'd1,
    ERR_SEG_VAL  = 3'd2,
    ERR_OFS_ADDR = 3'd3,
    ERR_OFS_VAL  = 3'd4,
    ERR_RD_ADDR  = 3'd5
  } fetchErr_e;

  typedef enum logic [3:0] {
    STEP_START_SEG = 4'd0,
    STEP_SEG_ADDR  = 4'd1,
    STEP_SEG_VAL   = 4'd2,
    STEP_START_OFS = 4'd3,
    STEP_OFS_ADDR  = 4'd4,
    STEP_OFS_VAL   = 4'd5,
    STEP_START_RD  = 4'd6,
    STEP_RD_ADDR   = 4'd7,
    STEP_READ      = 4'd8,
    STEP_STOP      = 4'd9,
    STEP_ABORT     = 4'd10
  } step_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAll;
    logic rdByte;
    logic nextBlock;
  } dpStrobe_t;

  localparam logic [7:0] SEG_DEV_WR  = 8'h60;
  localparam logic [7:0] TBL_DEV_WR  = 8'hA0;
  localparam logic [7:0] TBL_DEV_RD  = 8'hA1;
  localparam int         BLOCK_BYTES = 128;

endpackage

// File: rtl/edid_fetch_dp.sv
module edid_fetch_dp
  import edid_fetch_pkg::*;
#(
  parameter int MAX_BLOCKS = 4,
  localparam int CW = $clog2(MAX_BLOCKS + 1),
  localparam int AW = $clog2(MAX_BLOCKS * BLOCK_BYTES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strobe,
  input  logic [7:0]            rdData,
  output logic                  lastByte,
  output logic                  moreBlocks,
  output logic [7:0]            segByte,
  output logic [7:0]            ofsByte,
  output logic                  bufWrEn,
  output logic [AW-1:0]         bufWrAddr,
  output logic [7:0]            bufWrData,
  output logic                  hdrBad,
  output logic [MAX_BLOCKS-1:0] blockBad,
  output logic [CW-1:0]         blockCount
);

  logic [CW-1:0]         curBlock;
  logic [6:0]            byteIdx;
  logic [7:0]            sumAcc;
  logic                  hdrBadR;
  logic                  block0Bad;
  logic [CW-1:0]         targetBlocks;
  logic [CW-1:0]         blockCountR;
  logic [MAX_BLOCKS-1:0] blockBadR;

  logic [7:0] sumNext;
  logic       inHeader;
  logic       headerMiss;
  logic       blockFails;
  logic [8:0] declaredTotal;
  logic [CW-1:0] clampedTotal;

  function automatic logic [7:0] headerByte(input logic [2:0] idx);
    return (idx == 3'd0 || idx == 3'd7) ? 8'h00 : 8'hFF;
  endfunction

  assign sumNext       = sumAcc + rdData;
  assign inHeader      = (curBlock == '0) && (byteIdx < 7'd8);
  assign headerMiss    = inHeader && (rdData != headerByte(byteIdx[2:0]));
  assign blockFails    = (sumNext != 8'h00) || ((curBlock == '0) && hdrBadR);
  assign declaredTotal = {1'b0, rdData} + 9'd1;
  assign clampedTotal  = (declaredTotal > 9'(MAX_BLOCKS)) ? CW'(MAX_BLOCKS)
                                                          : CW'(declaredTotal);

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrAll) begin
      curBlock     <= '0;
      byteIdx      <= '0;
      sumAcc       <= '0;
      hdrBadR      <= 1'b0;
      block0Bad    <= 1'b0;
      targetBlocks <= CW'(1);
      blockCountR  <= '0;
    end else begin
      if (strobe.rdByte) begin
        byteIdx <= byteIdx + 7'd1;
        if (headerMiss) hdrBadR <= 1'b1;
        if ((curBlock == '0) && (byteIdx == 7'd126)) targetBlocks <= clampedTotal;
        if (byteIdx == 7'd127) begin
          sumAcc      <= 8'h00;
          blockCountR <= blockCountR + CW'(1);
          if (curBlock == '0) block0Bad <= blockFails;
        end else begin
          sumAcc <= sumNext;
        end
      end
      if (strobe.nextBlock) curBlock <= curBlock + CW'(1);
    end
  end

  // per-block flag registers
  for (genvar b = 0; b < MAX_BLOCKS; b++) begin : g_badFlag
    always_ff @(posedge clk) begin
      if (!rstN || strobe.clrAll) begin
        blockBadR[b] <= 1'b0;
      end else if (strobe.rdByte && (byteIdx == 7'd127) && (curBlock == CW'(b))) begin
        blockBadR[b] <= blockFails;
      end
    end
  end

  assign lastByte   = (byteIdx == 7'd127);
  assign moreBlocks = !block0Bad && (({1'b0, curBlock} + 1'b1) < {1'b0, targetBlocks});
  assign segByte    = 8'(curBlock >> 1);
  assign ofsByte    = curBlock[0] ? 8'h80 : 8'h00;

  assign bufWrEn    = strobe.rdByte;
  assign bufWrAddr  = AW'({curBlock, byteIdx});
  assign bufWrData  = rdData;

  assign hdrBad     = hdrBadR;
  assign blockBad   = blockBadR;
  assign blockCount = blockCountR;

  AST_COUNT_CLAMP: assert property (@(posedge clk) disable iff (!rstN)
    blockCountR <= CW'(MAX_BLOCKS)) else $error("count above capacity"); // R7

  AST_BAD0_HALTS: assert property (@(posedge clk) disable iff (!rstN)
    block0Bad |-> (curBlock == '0)) else $error("advanced past bad block 0"); // R8

  AST_FLAGS_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (blockBadR >> blockCountR) == '0) else $error("flag on unfetched block"); // R5

  AST_BYTE_STEP: assert property (@(posedge clk) disable iff (!rstN || strobe.clrAll)
    strobe.rdByte |=> (byteIdx == $past(byteIdx) + 7'd1)) else $error("byte index skipped"); // R4

endmodule

// File: rtl/edid_fetch_ctrl.sv
module edid_fetch_ctrl
  import edid_fetch_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       fetchStart,
  input  logic       hpdStable,
  input  logic       i2cDone,
  input  logic       i2cNack,
  input  logic       lastByte,
  input  logic       moreBlocks,
  input  logic [7:0] segByte,
  input  logic [7:0] ofsByte,
  output logic       cmdValid,
  output logic [1:0] cmdOp,
  output logic [7:0] cmdData,
  output logic       ackOut,
  output dpStrobe_t  strobe,
  output logic       busy,
  output logic       done,
  output logic [2:0] errCode
);

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HPD  = 3'd1,
    ST_CMD  = 3'd2,
    ST_WAIT = 3'd3,
    ST_FIN  = 3'd4
  } state_e;

  state_e    state;
  step_e     step;
  fetchErr_e errR;

  step_e     nxtStep;
  logic      goFin;
  logic      isWriteStep;
  fetchErr_e stepErr;
  i2cOp_e    opSel;
  logic      respHere;

  // command presented for the current step
  always_comb begin
    opSel   = OP_START;
    cmdData = 8'h00;
    unique case (step)
      STEP_SEG_ADDR: begin opSel = OP_WRITE; cmdData = SEG_DEV_WR; end
      STEP_SEG_VAL:  begin opSel = OP_WRITE; cmdData = segByte;    end
      STEP_OFS_ADDR: begin opSel = OP_WRITE; cmdData = TBL_DEV_WR; end
      STEP_OFS_VAL:  begin opSel = OP_WRITE; cmdData = ofsByte;    end
      STEP_RD_ADDR:  begin opSel = OP_WRITE; cmdData = TBL_DEV_RD; end
      STEP_READ:     opSel = OP_READ;
      STEP_STOP, STEP_ABORT: opSel = OP_STOP;
      default:       opSel = OP_START;
    endcase
  end

  always_comb begin
    isWriteStep = 1'b1;
    stepErr     = ERR_NONE;
    unique case (step)
      STEP_SEG_ADDR: stepErr = ERR_SEG_ADDR;
      STEP_SEG_VAL:  stepErr = ERR_SEG_VAL;
      STEP_OFS_ADDR: stepErr = ERR_OFS_ADDR;
      STEP_OFS_VAL:  stepErr = ERR_OFS_VAL;
      STEP_RD_ADDR:  stepErr = ERR_RD_ADDR;
      default:       isWriteStep = 1'b0;
    endcase
  end

  // sequencing once the engine answers
  always_comb begin
    nxtStep = step;
    goFin   = 1'b0;
    unique case (step)
      STEP_START_SEG: nxtStep = STEP_SEG_ADDR;
      STEP_SEG_ADDR:  nxtStep = i2cNack ? STEP_ABORT : STEP_SEG_VAL;
      STEP_SEG_VAL:   nxtStep = i2cNack ? STEP_ABORT : STEP_START_OFS;
      STEP_START_OFS: nxtStep = STEP_OFS_ADDR;
      STEP_OFS_ADDR:  nxtStep = i2cNack ? STEP_ABORT : STEP_OFS_VAL;
      STEP_OFS_VAL:   nxtStep = i2cNack ? STEP_ABORT : STEP_START_RD;
      STEP_START_RD:  nxtStep = STEP_RD_ADDR;
      STEP_RD_ADDR:   nxtStep = i2cNack ? STEP_ABORT : STEP_READ;
      STEP_READ:      nxtStep = lastByte ? STEP_STOP : STEP_READ;
      STEP_STOP: begin
        nxtStep = STEP_START_SEG;
        goFin   = !moreBlocks;
      end
      default:        goFin   = 1'b1;
    endcase
  end

  assign respHere = (state == ST_WAIT) && i2cDone;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      step  <= STEP_START_SEG;
      errR  <= ERR_NONE;
    end else begin
      unique case (state)
        ST_IDLE, ST_FIN: if (fetchStart) begin
          state <= ST_HPD;
          step  <= STEP_START_SEG;
          errR  <= ERR_NONE;
        end
        ST_HPD:  if (hpdStable) state <= ST_CMD;
        ST_CMD:  state <= ST_WAIT;
        ST_WAIT: if (i2cDone) begin
          step  <= nxtStep;
          state <= goFin ? ST_FIN : ST_CMD;
          if (isWriteStep && i2cNack) errR <= stepErr;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign strobe.clrAll    = ((state == ST_IDLE) || (state == ST_FIN)) && fetchStart;
  assign strobe.rdByte    = respHere && (step == STEP_READ);
  assign strobe.nextBlock = respHere && (step == STEP_STOP) && moreBlocks;

  assign cmdValid = (state == ST_CMD);
  assign cmdOp    = opSel;
  assign ackOut   = (step == STEP_READ) && !lastByte;
  assign busy     = (state == ST_HPD) || (state == ST_CMD) || (state == ST_WAIT);
  assign done     = (state == ST_FIN);
  assign errCode  = errR;

  AST_CMD_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid) else $error("command held"); // R11

  AST_HPD_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !cmdValid && !hpdStable && state == ST_HPD) |=> !cmdValid) else $error("cmd before hpd"); // R1

  AST_NACK_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (respHere && isWriteStep && i2cNack) |=> (cmdValid && cmdOp == OP_STOP)) else $error("no stop after nack"); // R9

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (done && !fetchStart) |=> (done && $stable(errCode))) else $error("result moved"); // R10

endmodule

// File: rtl/edid_fetch_seq.sv
module edid_fetch_seq
  import edid_fetch_pkg::*;
#(
  parameter int MAX_BLOCKS = 4,
  localparam int CW = $clog2(MAX_BLOCKS + 1),
  localparam int AW = $clog2(MAX_BLOCKS * BLOCK_BYTES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  fetchStart,
  input  logic                  hpdStable,
  output logic                  i2cCmdValid,
  output logic [1:0]            i2cCmdOp,
  output logic [7:0]            i2cCmdData,
  output logic                  i2cAckOut,
  input  logic                  i2cDone,
  input  logic [7:0]            i2cRdData,
  input  logic                  i2cNack,
  output logic                  bufWrEn,
  output logic [AW-1:0]         bufWrAddr,
  output logic [7:0]            bufWrData,
  output logic                  busy,
  output logic                  done,
  output logic [2:0]            errCode,
  output logic                  hdrBad,
  output logic [MAX_BLOCKS-1:0] blockBad,
  output logic [CW-1:0]         blockCount
);

  dpStrobe_t  strobe;
  logic       lastByte;
  logic       moreBlocks;
  logic [7:0] segByte;
  logic [7:0] ofsByte;

  edid_fetch_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .fetchStart (fetchStart),
    .hpdStable  (hpdStable),
    .i2cDone    (i2cDone),
    .i2cNack    (i2cNack),
    .lastByte   (lastByte),
    .moreBlocks (moreBlocks),
    .segByte    (segByte),
    .ofsByte    (ofsByte),
    .cmdValid   (i2cCmdValid),
    .cmdOp      (i2cCmdOp),
    .cmdData    (i2cCmdData),
    .ackOut     (i2cAckOut),
    .strobe     (strobe),
    .busy       (busy),
    .done       (done),
    .errCode    (errCode)
  );

  edid_fetch_dp #(.MAX_BLOCKS(MAX_BLOCKS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .rdData     (i2cRdData),
    .lastByte   (lastByte),
    .moreBlocks (moreBlocks),
    .segByte    (segByte),
    .ofsByte    (ofsByte),
    .bufWrEn    (bufWrEn),
    .bufWrAddr  (bufWrAddr),
    .bufWrData  (bufWrData),
    .hdrBad     (hdrBad),
    .blockBad   (blockBad),
    .blockCount (blockCount)
  );

endmodule

// File: tb/edid_fetch_seq_bench.sv
`timescale 1ns/1ps
module edid_fetch_seq_bench;

  localparam int MAXB = 4;
  localparam int CW   = $clog2(MAXB + 1);
  localparam int AW   = $clog2(MAXB * 128);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fetchStart = 1'b0;
  logic hpdStable = 1'b1;
  logic i2cCmdValid;
  logic [1:0] i2cCmdOp;
  logic [7:0] i2cCmdData;
  logic i2cAckOut;
  logic i2cDone = 1'b0;
  logic [7:0] i2cRdData = 8'h00;
  logic i2cNack = 1'b0;
  logic bufWrEn;
  logic [AW-1:0] bufWrAddr;
  logic [7:0] bufWrData;
  logic busy, done, hdrBad;
  logic [2:0] errCode;
  logic [MAXB-1:0] blockBad;
  logic [CW-1:0] blockCount;

  always #2.5 clk = ~clk;

  edid_fetch_seq #(.MAX_BLOCKS(MAXB)) u_edid_fetch_seq (
    .clk(clk), .rstN(rstN), .fetchStart(fetchStart), .hpdStable(hpdStable),
    .i2cCmdValid(i2cCmdValid), .i2cCmdOp(i2cCmdOp), .i2cCmdData(i2cCmdData),
    .i2cAckOut(i2cAckOut), .i2cDone(i2cDone), .i2cRdData(i2cRdData), .i2cNack(i2cNack),
    .bufWrEn(bufWrEn), .bufWrAddr(bufWrAddr), .bufWrData(bufWrData),
    .busy(busy), .done(done), .errCode(errCode), .hdrBad(hdrBad),
    .blockBad(blockBad), .blockCount(blockCount)
  );

  int checks = 0;
  int errors = 0;

  // sink image: 8 blocks laid out linearly, segment s covers bytes s*256..
  logic [7:0] sinkMem [0:1023];
  logic [7:0] benchBuf [0:MAXB*128-1];
  logic       seen [0:MAXB*128-1];

  // engine statistics per fetch
  int seg = 0, ptr = 0, phase = 0;
  int rdCnt, ackErr, wrCnt, cmdNoHpd, wrTotal, rdInBlk, lastOp, nackAt;
  logic [7:0] firstWr [0:1];

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // byte-level I2C slave model
  initial begin
    int lat;
    logic [1:0] op;
    logic [7:0] d, rd;
    logic ack, nk;
    int idx;
    forever begin
      @(posedge clk);
      if (i2cCmdValid) begin
        op = i2cCmdOp; d = i2cCmdData; ack = i2cAckOut;
        if (!hpdStable) cmdNoHpd++;
        lastOp = int'(op); nk = 1'b0; rd = 8'h00;
        case (op)
          2'd0: phase = 1;
          2'd1: begin
            if (wrCnt < 2) firstWr[wrCnt] = d;
            if (wrCnt == nackAt) nk = 1'b1;
            wrCnt++;
            if (!nk) begin
              case (phase)
                1: phase = (d == 8'h60) ? 2 : (d == 8'hA0) ? 3 : (d == 8'hA1) ? 4 : 5;
                2: begin seg = int'(d); phase = 5; end
                3: begin ptr = int'(d); phase = 5; end
                default: phase = 5;
              endcase
            end
          end
          2'd2: begin
            idx = seg * 256 + ptr;
            rd = (idx < 1024) ? sinkMem[idx] : 8'hFF;
            ptr = (ptr + 1) % 256;
            if (ack !== (rdInBlk != 127)) ackErr++;
            rdInBlk = (rdInBlk + 1) % 128;
            rdCnt++;
          end
          default: phase = 0;
        endcase
        lat = $urandom % 3;
        repeat (lat) @(posedge clk);
        #1 i2cDone = 1'b1; i2cRdData = rd; i2cNack = nk;
        @(posedge clk);
        #1 i2cDone = 1'b0; i2cNack = 1'b0;
      end
    end
  end

  // buffer capture away from the edge
  initial forever begin
    @(negedge clk);
    if (bufWrEn) begin
      benchBuf[bufWrAddr] = bufWrData;
      seen[bufWrAddr] = 1'b1;
      wrTotal++;
    end
  end

  task automatic buildSink(input int n, input bit hdrC, input int badMask);
    for (int b = 0; b < 8; b++) begin
      logic [7:0] s;
      for (int i = 0; i < 127; i++) sinkMem[b*128+i] = 8'($urandom);
      if (b == 0) begin
        for (int i = 0; i < 8; i++) sinkMem[i] = (i == 0 || i == 7) ? 8'h00 : 8'hFF;
        if (hdrC) sinkMem[3] = 8'hFE;
        sinkMem[126] = 8'(n);
      end
      s = 8'h00;
      for (int i = 0; i < 127; i++) s = s + sinkMem[b*128+i];
      sinkMem[b*128+127] = 8'h00 - s;
      if (badMask[b]) sinkMem[b*128+127] = sinkMem[b*128+127] ^ 8'h5A;
    end
  endtask

  task automatic doFetch(input int n, input bit hdrC, input int badMask,
                         input int nackK, input int hpdWait, input string tag);
    int total, expCount, expErr, mism, expBad;
    bit bad0;
    buildSink(n, hdrC, badMask);
    for (int i = 0; i < MAXB*128; i++) seen[i] = 1'b0;
    rdCnt = 0; ackErr = 0; wrCnt = 0; cmdNoHpd = 0; wrTotal = 0; rdInBlk = 0;
    lastOp = -1; nackAt = nackK; firstWr[0] = 8'hEE; firstWr[1] = 8'hEE;
    if (hpdWait > 0) hpdStable = 1'b0;
    @(negedge clk) fetchStart = 1'b1;
    @(negedge clk) fetchStart = 1'b0;
    if (hpdWait > 0) begin
      repeat (hpdWait) @(negedge clk);
      chk("R1", int'(busy), 1, {tag, " busy while waiting hpd"});
      chk("R1", cmdNoHpd + rdCnt + wrCnt, 0, {tag, " commands before hpd"});
      hpdStable = 1'b1;
    end
    // fetchStart while busy must not restart
    repeat (3) @(negedge clk);
    fetchStart = 1'b1;
    @(negedge clk) fetchStart = 1'b0;
    while (!done) @(negedge clk);

    total = (n + 1 < MAXB) ? n + 1 : MAXB;
    bad0  = hdrC || badMask[0];
    if (bad0) total = 1;
    if (nackK >= 0) begin expCount = nackK / 5; expErr = nackK % 5 + 1; end
    else begin expCount = total; expErr = 0; end
    expBad = 0;
    for (int b = 0; b < expCount; b++)
      if ((b == 0) ? bad0 : badMask[b]) expBad |= (1 << b);

    chk("R7", int'(blockCount), expCount, {tag, " blockCount"});
    chk("R9", int'(errCode), expErr, {tag, " errCode"});
    chk("R5", int'(blockBad), expBad, {tag, " blockBad"});
    chk("R6", int'(hdrBad), (hdrC && expCount >= 1) ? 1 : 0, {tag, " hdrBad"});
    chk("R3", ackErr, 0, {tag, " ack pattern"});
    chk("R8", rdCnt, 128 * expCount, {tag, " bytes read"});
    chk("R2", lastOp, 3, {tag, " ends with STOP"});
    if (nackK < 0 || nackK > 1) begin
      chk("R2", int'(firstWr[0]), 8'h60, {tag, " first write segment device"});
      chk("R2", int'(firstWr[1]), 8'h00, {tag, " block 0 segment value"});
    end
    mism = 0;
    for (int b = 0; b < expCount; b++)
      for (int i = 0; i < 128; i++)
        if (!seen[b*128+i] || benchBuf[b*128+i] !== sinkMem[b*128+i]) mism++;
    chk("R4", mism, 0, {tag, " buffer mismatches"});
    chk("R4", wrTotal, 128 * expCount, {tag, " buffer writes"});
    repeat (15) @(negedge clk);
    chk("R10", int'(done), 1, {tag, " done held"});
    chk("R10", int'(blockCount), expCount, {tag, " count held"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10", int'(busy), 0, "reset busy");
    chk("R10", int'(done), 0, "reset done");
    chk("R7", int'(blockCount), 0, "reset blockCount");
    chk("R9", int'(errCode), 0, "reset errCode");
    chk("R11", int'(i2cCmdValid), 0, "reset cmdValid");

    doFetch(0,   1'b0, 0,     -1, 0,  "single block");
    doFetch(3,   1'b0, 0,     -1, 0,  "four blocks two segments");
    doFetch(1,   1'b0, 0,     -1, 0,  "segment rewritten after seg1");  // R2
    doFetch(9,   1'b0, 0,     -1, 0,  "clamp N=9");                      // R7
    doFetch(255, 1'b0, 0,     -1, 0,  "clamp N=255");                    // R7
    doFetch(3,   1'b1, 0,     -1, 0,  "bad header halts");               // R6 R8
    doFetch(3,   1'b0, 1,     -1, 0,  "bad block0 checksum halts");      // R8
    doFetch(3,   1'b0, 4'b0100, -1, 0, "bad block2 checksum");           // R5
    doFetch(2,   1'b0, 0,     -1, 40, "hpd late");                       // R1
    for (int k = 0; k < 5; k++) doFetch(1, 1'b0, 0, k, 0, "nack block0 step");  // R9
    doFetch(3,   1'b0, 0,     12, 0,  "nack block2 offset addr");        // R9
    doFetch(3,   1'b0, 0,     19, 0,  "nack block3 read addr");          // R9
    for (int it = 0; it < 8; it++) begin
      int n, bm, k, tot;
      bit hc;
      n  = $urandom % 6;
      bm = $urandom % 16;
      hc = ($urandom % 4) == 0;
      tot = (n + 1 < MAXB) ? n + 1 : MAXB;
      if (hc || bm[0]) tot = 1;
      k  = (($urandom % 3) == 0) ? int'($urandom % (5 * tot)) : -1;
      doFetch(n, hc, bm, k, int'($urandom % 2) * 10, "random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule